// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Reset-Latched Read Mode

This block is a single-clock FIFO queue. Its read behaviour is chosen once, when master reset is released. In **standard** mode a consumer must ask for every word, the first one included, and the word arrives on the output after the requesting edge. In **fall-through** mode the queue moves the oldest word onto the output without a request. A read then retires the presented word and brings the next one forward.

The same two flag outputs carry different meanings in the two modes. In standard mode they are empty and full. In fall-through mode they are output-ready and input-ready. Two threshold flags, almost-empty and almost-full, compare against offsets fixed at elaboration.

On the write side, `wr_en` is the producer's valid. The back-pressure signal is "full" (standard) or "input-ready deasserted" (fall-through). A word offered while the queue holds `DEPTH` words is dropped, so the producer must hold off while back-pressure shows. On the read side, a request is the pair `rd_en` and `rd_sel` together. A request made while no word is available is ignored.

Two resets are provided:
- The asynchronous master reset clears everything and reopens the mode choice.
- A synchronous partial reset empties the queue but keeps the latched mode.

`DEPTH` must be a power of two.

Top module: `dual_mode_fifo`

## Requirements
- R1: `fwft_sel` is captured at the first rising clock edge after `mrst_n` goes high (0 = standard, 1 = fall-through). Later changes of `fwft_sel` have no effect until the next master reset.
- R2: While `mrst_n` is low, `rd_data` is all zeros, `pae_n` is 0 and `paf_n` is 1. The flags are as follows:
  - In standard mode, `ef_or_n` is 0 and `ff_ir_n` is 1.
  - In fall-through mode, `ef_or_n` is 1 and `ff_ir_n` is 0.
- R3: In standard mode, a word is delivered to `rd_data` only at a rising edge where `rd_en` and `rd_sel` are both 1. It is visible after that edge. Otherwise `rd_data` holds its value.
- R4: In fall-through mode, a word written into an empty queue is on `rd_data` with `ef_or_n` = 0 after the third rising edge, counting the write edge as the first. No read request is needed for this.
- R5: In fall-through mode, a read with `rd_en` and `rd_sel` both 1 retires the presented word. The next stored word is then on `rd_data` after that edge. Without both signals, the presented word stays.
- R6: When `DEPTH` words are stored, a write is dropped and back-pressure is shown:
  - In standard mode, `ff_ir_n` = 0 when full and 1 otherwise.
  - In fall-through mode, `ff_ir_n` = 1 when full and 0 otherwise.
- R7: A read request while the queue is empty (standard), or while no word is presented (fall-through), changes no stored state. In standard mode it also leaves `rd_data` unchanged.
- R8: `pae_n` is 0 exactly when the occupancy is at or below `AE_OFF`.
- R9: `paf_n` is 0 exactly when `DEPTH` minus the occupancy is at or below `AF_OFF`.
- R10: Holding `prst_n` low at a rising edge empties the queue, and `pae_n`/`paf_n` return to their empty values. The latched mode, and with it the flag meanings, is kept.
- R11: The status flag encodings are:
  - In standard mode, `ef_or_n` = 0 means empty and `ff_ir_n` = 0 means full.
  - In fall-through mode, `ef_or_n` = 0 means a word is presented and `ff_ir_n` = 0 means space is free.
- R12: Words leave the queue in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| fwft_sel | input | 1 | Read-mode choice captured after master reset |
| wr_en | input | 1 | Write request (producer valid) |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read enable |
| rd_sel | input | 1 | Read select, qualifies `rd_en` |
| rd_data | output | DW | Output data register |
| ef_or_n | output | 1 | Empty (standard) / output-ready (fall-through), active low |
| ff_ir_n | output | 1 | Full (standard) / input-ready (fall-through), active low |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
The results fall due at different cycles:
- The occupancy-based flags (full/input-ready, almost-empty, almost-full and the standard empty flag) change in the cycle right after the accepting or retiring edge.
- A standard-mode read shows its word one edge after the request.
- A fall-through first word needs three edges from the write edge.

The bench drives inputs on falling edges and samples on the next falling edge. For fall-through fills it waits two idle cycles before comparing output-ready and data. The fall-through latency is probed edge by edge, so the second edge must still show "not ready" and the third must show the word.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FWFT     = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_cfg_latch.sv
module dmf_cfg_latch
  import dmf_pkg::*;
(
  input  logic     clk,
  input  logic     mrst_n,
  input  logic     fwft_sel,
  output rd_mode_e mode_eff
);
  logic     cfg_open;
  rd_mode_e mode_q;

  // The window opens asynchronously with master reset and closes at the
  // first rising edge after release, where the selection is captured.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      cfg_open <= 1'b1;
      mode_q   <= RD_STANDARD;
    end else if (cfg_open) begin
      cfg_open <= 1'b0;
      mode_q   <= rd_mode_e'(fwft_sel);
    end
  end

  // While the window is open the pin decides the flag meanings directly.
  assign mode_eff = cfg_open ? rd_mode_e'(fwft_sel) : mode_q;

  // R1: once captured, the mode never moves until the next master reset
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!mrst_n)
    (!cfg_open && $past(!cfg_open)) |-> $stable(mode_q));
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          mem_nz
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  assign head_data = mem[rptr[AW-1:0]];
  assign mem_nz    = (wptr != rptr);

  // R6: the pointer gap never exceeds the array size
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    (PW'(wptr - rptr) <= PW'(DEPTH)));

  // R7: the read side never retires from an empty array
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    pop |-> (wptr != rptr));
endmodule

// File: rtl/dmf_out_stage.sv
module dmf_out_stage
  import dmf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          clr,
  input  rd_mode_e      mode,
  input  logic          rd_req,
  input  logic          occ_nz,
  input  logic          mem_nz,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          take,
  output logic          out_valid,
  output logic [DW-1:0] rd_data
);
  logic          s1_valid;
  logic [DW-1:0] s1_data;
  logic          std_fire, out_take, out_load, s1_load, fwft;

  assign fwft     = (mode == RD_FWFT);
  assign std_fire = !fwft && rd_req && occ_nz && !clr;
  assign out_take = fwft && rd_req && out_valid && !clr;
  assign out_load = fwft && s1_valid && (!out_valid || out_take) && !clr;
  assign s1_load  = fwft && mem_nz && (!s1_valid || out_load) && !clr;

  assign pop  = std_fire || s1_load;
  assign take = std_fire || out_take;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      s1_valid  <= 1'b0;
      s1_data   <= '0;
      out_valid <= 1'b0;
      rd_data   <= '0;
    end else if (clr) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (std_fire) rd_data <= head_data;
      if (s1_load) begin
        s1_data  <= head_data;
        s1_valid <= 1'b1;
      end else if (out_load) begin
        s1_valid <= 1'b0;
      end
      if (out_load) begin
        rd_data   <= s1_data;
        out_valid <= 1'b1;
      end else if (out_take) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R4: a staged word always reaches an idle output register on the next edge
  p_fwft_advance_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    (s1_valid && !out_valid && !clr) |=> out_valid);
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AE_OFF = 2,
  parameter int AF_OFF = 2
) (
  input  logic                       clk,
  input  logic                       mrst_n,
  input  logic                       clr,
  input  logic                       inc,
  input  logic                       dec,
  input  rd_mode_e                   mode,
  input  logic                       out_valid,
  output logic [$clog2(DEPTH):0]     occ,
  output logic                       full,
  output logic                       ef_or_n,
  output logic                       ff_ir_n,
  output logic                       pae_n,
  output logic                       paf_n
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
  localparam logic [CW-1:0] AE_V    = CW'(AE_OFF);
  localparam logic [CW-1:0] AF_V    = CW'(AF_OFF);

  logic [CW-1:0] free;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n)         occ <= '0;
    else if (clr)        occ <= '0;
    else if (inc && !dec) occ <= occ + 1'b1;
    else if (dec && !inc) occ <= occ - 1'b1;
  end

  assign full = (occ == DEPTH_V);
  assign free = DEPTH_V - occ;

  // The flag pair flips meaning (and rest level) with the mode.
  always_comb begin
    if (mode == RD_FWFT) begin
      ef_or_n = !out_valid;
      ff_ir_n = full;
    end else begin
      ef_or_n = (occ != '0);
      ff_ir_n = !full;
    end
  end

  assign pae_n = !(occ <= AE_V);
  assign paf_n = !(free <= AF_V);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int AE_OFF = 2,
  parameter int AF_OFF = 2
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          ef_or_n,
  output logic          ff_ir_n,
  output logic          pae_n,
  output logic          paf_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  rd_mode_e      mode;
  logic          clr, wr_acc, full, pop, take, out_valid, mem_nz;
  logic [DW-1:0] head_data;
  logic [CW-1:0] occ;

  assign clr    = !prst_n;
  assign wr_acc = wr_en && !full && !clr;

  dmf_cfg_latch u_cfg (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .fwft_sel (fwft_sel),
    .mode_eff (mode)
  );

  dmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .clr       (clr),
    .push      (wr_acc),
    .push_data (wr_data),
    .pop       (pop),
    .head_data (head_data),
    .mem_nz    (mem_nz)
  );

  dmf_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .clr       (clr),
    .mode      (mode),
    .rd_req    (rd_en && rd_sel),
    .occ_nz    (occ != '0),
    .mem_nz    (mem_nz),
    .head_data (head_data),
    .pop       (pop),
    .take      (take),
    .out_valid (out_valid),
    .rd_data   (rd_data)
  );

  dmf_flags #(.DEPTH(DEPTH), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) u_flags (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .clr       (clr),
    .inc       (wr_acc),
    .dec       (take),
    .mode      (mode),
    .out_valid (out_valid),
    .occ       (occ),
    .full      (full),
    .ef_or_n   (ef_or_n),
    .ff_ir_n   (ff_ir_n),
    .pae_n     (pae_n),
    .paf_n     (paf_n)
  );

  // R5: a presented word is always backed by the occupancy count
  p_out_backed_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    out_valid |-> (occ != '0));

  // R10: partial reset leaves the queue empty on the following cycle
  p_prst_clears_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ((occ == '0) && !out_valid));
endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
  localparam int DW = 8, DEPTH = 8, AE = 2, AF = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrst_n, prst_n, fwft_sel, wr_en, rd_en, rd_sel;
  logic [DW-1:0] wr_data, rd_data;
  logic ef_or_n, ff_ir_n, pae_n, paf_n;

  dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) u_dual_mode_fifo (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n),
    .pae_n(pae_n), .paf_n(paf_n)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] last_out;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_flags(input bit m, input string req);
    int occ;
    bit e_ef, e_ff, e_ae, e_af;
    occ  = mq.size();
    e_ef = m ? (occ == 0) : (occ != 0);
    e_ff = m ? (occ == DEPTH) : (occ != DEPTH);
    e_ae = !(occ <= AE);
    e_af = !((DEPTH - occ) <= AF);
    check(ef_or_n == e_ef, {req, " ef_or_n (R11)"}, ef_or_n, e_ef);
    check(ff_ir_n == e_ff, {req, " ff_ir_n (R6)"}, ff_ir_n, e_ff);
    check(pae_n == e_ae, {req, " pae_n (R8)"}, pae_n, e_ae);
    check(paf_n == e_af, {req, " paf_n (R9)"}, paf_n, e_af);
  endtask

  task automatic write_word(input logic [DW-1:0] d, input bit m);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(d);
    if (m) begin step(); step(); end
  endtask

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; rd_sel = 1'b0;
    for (int mi = 0; mi < 2; mi++) begin
      bit m;
      m = mi[0];
      @(negedge clk);
      mrst_n = 1'b0; fwft_sel = m;
      step(); step();
      // R2 reset-state flag levels and zeroed data
      check(ef_or_n == m, "R2 ef_or_n in reset", ef_or_n, m);
      check(ff_ir_n == !m, "R2 ff_ir_n in reset", ff_ir_n, !m);
      check(pae_n == 1'b0, "R2 pae_n in reset", pae_n, 0);
      check(paf_n == 1'b1, "R2 paf_n in reset", paf_n, 1);
      check(rd_data == '0, "R2 rd_data in reset", rd_data, 0);
      mq.delete(); last_out = '0;
      mrst_n = 1'b1;
      step();
      fwft_sel = !m;   // R1: late change must be ignored
      step();
      check_flags(m, "R1 mode kept");

      if (m) begin
        // R4 first word latency, edge by edge
        wr_en = 1'b1; wr_data = 8'hA5;
        step();
        wr_en = 1'b0;
        check(ef_or_n == 1'b1, "R4 after edge 1", ef_or_n, 1);
        step();
        check(ef_or_n == 1'b1, "R4 after edge 2", ef_or_n, 1);
        step();
        check(ef_or_n == 1'b0, "R4 after edge 3", ef_or_n, 0);
        check(rd_data == 8'hA5, "R4 data", rd_data, 8'hA5);
        rd_en = 1'b1; rd_sel = 1'b1;
        step();
        rd_en = 1'b0; rd_sel = 1'b0;
        check(ef_or_n == 1'b1, "R5 retired last word", ef_or_n, 1);
      end else begin
        wr_en = 1'b1; wr_data = 8'h5A;
        step();
        wr_en = 1'b0;
        check(rd_data == '0, "R3 no delivery without read", rd_data, 0);
        rd_en = 1'b1; rd_sel = 1'b0;
        step();
        check(rd_data == '0, "R3 rd_sel low blocks read", rd_data, 0);
        rd_sel = 1'b1;
        step();
        rd_en = 1'b0; rd_sel = 1'b0;
        check(rd_data == 8'h5A, "R3 delivered on request", rd_data, 8'h5A);
        last_out = 8'h5A;
      end
      check_flags(m, "R7 emptied");

      // Fill sweep through every occupancy, plus one write while full (R6)
      for (int i = 0; i <= DEPTH; i++) begin
        write_word(DW'(i * 29 + mi * 7 + 3), m);
        check_flags(m, "R6 R8 R9 fill");
      end

      // Read enable without select: nothing moves
      rd_en = 1'b1; rd_sel = 1'b0;
      step();
      rd_en = 1'b0;
      check_flags(m, "R3 R5 unselected read");
      if (m) check(rd_data == mq[0], "R5 presented word held", rd_data, mq[0]);
      else   check(rd_data == last_out, "R3 output held", rd_data, last_out);

      // Drain sweep, one read per cycle, with one extra read on empty (R7)
      for (int i = 0; i <= DEPTH; i++) begin
        rd_en = 1'b1; rd_sel = 1'b1;
        step();
        rd_en = 1'b0; rd_sel = 1'b0;
        if (m) begin
          if (mq.size() > 0) void'(mq.pop_front());
          if (mq.size() > 0) check(rd_data == mq[0], "R5 R12 next word", rd_data, mq[0]);
        end else begin
          if (mq.size() > 0) last_out = mq.pop_front();
          check(rd_data == last_out, "R12 R7 order or ignored read", rd_data, last_out);
        end
        check_flags(m, "R7 R8 R9 drain");
      end

      // Partial reset keeps the mode, clears contents
      for (int i = 0; i < 3; i++) write_word(DW'(8'h70 + i), m);
      prst_n = 1'b0;
      step();
      prst_n = 1'b1;
      mq.delete();
      check_flags(m, "R10 after partial reset");
      write_word(8'h3C, m);
      if (!m) begin
        rd_en = 1'b1; rd_sel = 1'b1;
        step();
        rd_en = 1'b0; rd_sel = 1'b0;
        void'(mq.pop_front());
      end
      check(rd_data == 8'h3C, "R10 R12 fresh first word", rd_data, 8'h3C);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule